// File: doc/BRIEF.md
# Translation Cache with Hardware Table Walk

This block caches virtual-to-physical page mappings for a requester, such as a load/store pipeline. Each lookup presents a virtual address, an access type (read or write), a privilege level (user or supervisor) and the current address-space identifier. On a hit that the stored permissions allow, the block answers one cycle later with the physical address. The physical address is the cached frame number joined to the untranslated page offset. On a hit that the permissions forbid, it answers with a protection fault.

On a miss, the block fetches the page-table entry itself through a simple request/response memory port. The entry's address is the table base plus four times the virtual page number. The block then checks the presence and permission bits of the entry. If the entry is acceptable, the block installs it and tells the requester to retry. Otherwise it reports a segmentation fault or a protection fault and installs nothing.

The cache is fully associative. An entry matches when its identifier equals the current one or when its global bit is set. When the cache is full, a fill replaces the least recently used entry. A flush input invalidates every entry at once.

Top module: `xlat_cache`

## Requirements
- R1: A lookup that hits with sufficient permission produces, on the clock edge that accepts it, a response with resp_hit set and resp_paddr = {stored frame number, vaddr[11:0]}. No memory request is issued.
- R2: A lookup that misses raises mem_req_valid on the accepting edge, with mem_req_addr = ptbr + 4 * vaddr[31:12]. The request is held steady until mem_resp_valid, and no response is given before then.
- R3: A fetched entry with bit 0 (present) clear gives a response with resp_seg_fault and installs nothing, so a repeat of the same access walks again.
- R4: A fetched present entry that forbids the access gives resp_prot_fault and installs nothing. An access is forbidden when it is a write and bit 1 (writable) is clear, or when it comes from user mode and bit 2 (user) is clear.
- R5: A fetched present entry that permits the access is installed with its frame number (bits 31:12), bits 1, 2 and 8 and the current identifier, and the response is resp_retry. A repeat of the access then hits.
- R6: A hit whose stored permissions forbid the access, judged by the rule of R4, gives resp_prot_fault and no physical address.
- R7: An entry matches only when its identifier equals cur_asid or its global bit (entry bit 8) is set.
- R8: Asserting flush for one cycle invalidates every entry, so that every later lookup misses until refilled.
- R9: When all 8 entries are valid, a fill replaces the entry whose most recent hit or fill is the oldest.
- R10: Only one walk is outstanding at a time. req_ready is low during a walk and during flush, and each accepted lookup gets exactly one response pulse carrying exactly one of hit, retry, protection fault or segmentation fault. After reset req_ready is high and no response or memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_write | input | 1 | Lookup is a write |
| req_user | input | 1 | Lookup comes from user mode |
| cur_asid | input | 8 | Current address-space identifier |
| ptbr | input | 32 | Byte address of the page table |
| flush | input | 1 | Invalidate every entry |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Translation succeeded |
| resp_retry | output | 1 | Entry installed, repeat the access |
| resp_prot_fault | output | 1 | Access forbidden by permissions |
| resp_seg_fault | output | 1 | Page-table entry not present |
| resp_paddr | output | 32 | Physical address, meaningful with resp_hit |
| mem_req_valid | output | 1 | Page-table read pending |
| mem_req_addr | output | 32 | Address of the page-table entry |
| mem_resp_valid | input | 1 | Page-table read data present |
| mem_resp_data | input | 32 | Page-table entry read from memory |

## Verification
The assertions assume that the memory side returns exactly one mem_resp_valid pulse for each read, and only while a read is pending. They also assume that no context ever sees two entries for the same page, as a global entry and a private entry for one page number would be. The bench memory answers every read once, after a fixed delay. Its page set keeps global pages and private pages on different page numbers. Flush is applied only between lookups, while no walk is in progress.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PTE_PRESENT = 0;
  localparam int PTE_WRITE   = 1;
  localparam int PTE_USER    = 2;
  localparam int PTE_GLOBAL  = 8;

  function automatic logic perm_denied(input logic wr_ok, input logic usr_ok,
                                       input logic is_wr, input logic is_usr);
    return (is_wr && !wr_ok) || (is_usr && !usr_ok);
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             ent_v,
  input  logic [ENTRIES-1:0]             ent_g,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]               look_vpn,
  input  logic [ASID_W-1:0]              look_asid,
  output logic                           hit_any,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_vpn[g] == look_vpn) &&
                        (ent_g[g] || (ent_asid[g] == look_asid));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [ENTRIES-1:0][IDX_W-1:0] age;
  logic [ENTRIES-1:0]            oldest;
  logic                          found;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx])  age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest[g] = (age[g] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    victim_idx = '0;
    found      = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !valid_vec[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    if (!found)
      for (int i = 0; i < ENTRIES; i++)
        if (oldest[i]) victim_idx = IDX_W'(i);
  end

  // Ages stay a permutation, so exactly one entry is the oldest.
  assert_lru_single_oldest_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              flush,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_retry,
  output logic              resp_prot_fault,
  output logic              resp_seg_fault,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [ADDR_W-1:0] mem_resp_data
);
  import xlat_pkg::*;

  typedef enum logic {S_IDLE, S_WALK} state_t;
  state_t state;

  logic [ENTRIES-1:0]             ent_v, ent_g, ent_w, ent_u;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn, ent_pfn;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;

  logic [VPN_W-1:0]  lk_vpn;
  logic [ASID_W-1:0] lk_asid;
  logic              lk_wr, lk_usr;

  logic [VPN_W-1:0] look_vpn;
  logic             hit_any, accept, hit_bad, pte_bad, fill;
  logic [IDX_W-1:0] hit_idx, victim_idx, touch_idx;

  assign look_vpn  = req_vaddr[ADDR_W-1:PAGE_BITS];
  assign req_ready = (state == S_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign hit_bad   = perm_denied(ent_w[hit_idx], ent_u[hit_idx], req_write, req_user);
  assign pte_bad   = perm_denied(mem_resp_data[PTE_WRITE], mem_resp_data[PTE_USER],
                                 lk_wr, lk_usr);
  assign fill      = (state == S_WALK) && mem_resp_valid &&
                     mem_resp_data[PTE_PRESENT] && !pte_bad;
  assign touch_idx = fill ? victim_idx : hit_idx;

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .ent_v(ent_v), .ent_g(ent_g), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .look_vpn(look_vpn), .look_asid(cur_asid),
    .hit_any(hit_any), .hit_idx(hit_idx));

  xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch(fill || (accept && hit_any)),
    .touch_idx(touch_idx), .valid_vec(ent_v), .victim_idx(victim_idx));

  // Entry payload: no reset, written only on fill.
  always_ff @(posedge clk) begin
    if (fill) begin
      ent_vpn[victim_idx]  <= lk_vpn;
      ent_pfn[victim_idx]  <= mem_resp_data[ADDR_W-1:PAGE_BITS];
      ent_asid[victim_idx] <= lk_asid;
      ent_g[victim_idx]    <= mem_resp_data[PTE_GLOBAL];
      ent_w[victim_idx]    <= mem_resp_data[PTE_WRITE];
      ent_u[victim_idx]    <= mem_resp_data[PTE_USER];
    end
    if (accept) begin
      lk_vpn  <= look_vpn;
      lk_asid <= cur_asid;
      lk_wr   <= req_write;
      lk_usr  <= req_user;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= S_IDLE;
      ent_v           <= '0;
      resp_valid      <= 1'b0;
      resp_hit        <= 1'b0;
      resp_retry      <= 1'b0;
      resp_prot_fault <= 1'b0;
      resp_seg_fault  <= 1'b0;
      resp_paddr      <= '0;
      mem_req_valid   <= 1'b0;
      mem_req_addr    <= '0;
    end else begin
      resp_valid      <= 1'b0;
      resp_hit        <= 1'b0;
      resp_retry      <= 1'b0;
      resp_prot_fault <= 1'b0;
      resp_seg_fault  <= 1'b0;
      if (flush) ent_v <= '0;
      case (state)
        S_IDLE: if (accept) begin
          if (hit_any) begin
            resp_valid <= 1'b1;
            if (hit_bad) resp_prot_fault <= 1'b1;
            else begin
              resp_hit   <= 1'b1;
              resp_paddr <= {ent_pfn[hit_idx], req_vaddr[PAGE_BITS-1:0]};
            end
          end else begin
            state         <= S_WALK;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= ptbr + (ADDR_W'(look_vpn) << 2);
          end
        end
        S_WALK: if (mem_resp_valid) begin
          state         <= S_IDLE;
          mem_req_valid <= 1'b0;
          resp_valid    <= 1'b1;
          if (!mem_resp_data[PTE_PRESENT]) resp_seg_fault  <= 1'b1;
          else if (pte_bad)                resp_prot_fault <= 1'b1;
          else begin
            resp_retry        <= 1'b1;
            ent_v[victim_idx] <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_walk_stalls_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_WALK) |-> !req_ready);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $onehot({resp_hit, resp_retry, resp_prot_fault, resp_seg_fault}));

  assert_walk_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_no_resp_mid_walk_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_resp_valid) |=> !resp_valid);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && state == S_IDLE) |=> (ent_v == '0));

  assert_hit_offset_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(resp_hit) |-> (resp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam logic [31:0] PTBR = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, flush = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  cur_asid = '0;
  logic mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;
  logic req_ready, resp_valid, resp_hit, resp_retry, resp_prot_fault, resp_seg_fault;
  logic [31:0] resp_paddr, mem_req_addr;
  logic mem_req_valid;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int unsigned vpn;
    int unsigned pfn;
    int unsigned asid;
    bit g, w, u;
  } mentry_t;
  mentry_t model[$];
  logic [31:0] ptes [int unsigned];

  always #4 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .cur_asid(cur_asid), .ptbr(PTBR), .flush(flush),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_retry(resp_retry),
    .resp_prot_fault(resp_prot_fault), .resp_seg_fault(resp_seg_fault),
    .resp_paddr(resp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input int unsigned pfn, input bit p, input bit w,
                                         input bit u, input bit g);
    return {pfn[19:0], 3'b000, g, 5'b00000, u, w, p};
  endfunction

  // Outcome word: {valid, hit, retry, prot, seg}
  function automatic logic [4:0] outcome();
    return {resp_valid, resp_hit, resp_retry, resp_prot_fault, resp_seg_fault};
  endfunction

  task automatic access(input string req, input logic [31:0] va, input bit wr,
                        input bit usr, input logic [7:0] asid);
    int idx;
    int unsigned vpn;
    mentry_t e;
    logic [31:0] pte;
    bit bad;
    vpn = int'(va[31:12]);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; cur_asid = asid; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    idx = -1;
    foreach (model[i])
      if (idx < 0 && model[i].vpn == vpn && (model[i].g || model[i].asid == asid)) idx = i;
    if (idx >= 0) begin
      e = model[idx];
      model.delete(idx);
      model.push_back(e);
      bad = (wr && !e.w) || (usr && !e.u);
      check({req, " hit outcome"}, {58'd0, mem_req_valid, outcome()},
            {58'd0, 1'b0, 1'b1, !bad, 1'b0, bad, 1'b0});
      if (!bad) check({req, " paddr"}, 64'(resp_paddr), 64'({e.pfn[19:0], va[11:0]}));
    end else begin
      check({req, " walk request"}, {29'd0, mem_req_valid, req_ready, resp_valid, mem_req_addr},
            {29'd0, 1'b1, 1'b0, 1'b0, PTBR + (vpn << 2)});
      repeat (2) @(negedge clk);
      check({req, " walk wait"}, {61'd0, mem_req_valid, req_ready, resp_valid}, {61'd0, 3'b100});
      pte = ptes.exists(vpn) ? ptes[vpn] : 32'h0;
      mem_resp_valid = 1'b1; mem_resp_data = pte;
      @(negedge clk);
      mem_resp_valid = 1'b0; mem_resp_data = '0;
      bad = (wr && !pte[1]) || (usr && !pte[2]);
      if (!pte[0])
        check({req, " walk outcome"}, {59'd0, outcome()}, {59'd0, 5'b10001});
      else if (bad)
        check({req, " walk outcome"}, {59'd0, outcome()}, {59'd0, 5'b10010});
      else begin
        check({req, " walk outcome"}, {59'd0, outcome()}, {59'd0, 5'b10100});
        e.vpn = vpn; e.pfn = int'(pte[31:12]); e.asid = int'(asid);
        e.g = pte[8]; e.w = pte[1]; e.u = pte[2];
        if (model.size() == 8) void'(model.pop_front());
        model.push_back(e);
      end
      check({req, " walk done"}, {62'd0, mem_req_valid, req_ready}, {62'd0, 2'b01});
    end
    @(negedge clk);
    check({req, " single pulse R10"}, {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model.delete();
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ptes[32'h10] = mk_pte(32'h80, 1, 1, 1, 0);
    ptes[32'h11] = mk_pte(32'h81, 1, 0, 0, 0);
    ptes[32'h12] = mk_pte(32'h82, 0, 1, 1, 0);
    ptes[32'h13] = mk_pte(32'h83, 1, 1, 1, 1);
    ptes[32'h14] = mk_pte(32'h84, 1, 1, 0, 0);
    for (int i = 0; i < 9; i++) ptes[32'h20 + i] = mk_pte(32'h90 + i, 1, 1, 1, 0);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset state", {61'd0, req_ready, resp_valid, mem_req_valid}, {61'd0, 3'b100});

    access("R2 R5 first touch", 32'h0001_0ABC, 0, 1, 8'd1);
    access("R1 read hit", 32'h0001_0ABC, 0, 1, 8'd1);
    access("R1 write hit", 32'h0001_0FFF, 1, 1, 8'd1);
    access("R7 other asid misses", 32'h0001_0004, 0, 1, 8'd2);
    access("R7 other asid hit", 32'h0001_0008, 0, 1, 8'd2);
    access("R3 absent entry", 32'h0001_2000, 0, 0, 8'd1);
    access("R3 not installed", 32'h0001_2010, 0, 0, 8'd1);
    access("R4 user on supervisor page", 32'h0001_4000, 0, 1, 8'd1);
    access("R4 not installed", 32'h0001_4000, 0, 1, 8'd1);
    access("R5 supervisor fill", 32'h0001_4020, 0, 0, 8'd1);
    access("R6 user hit denied", 32'h0001_4020, 0, 1, 8'd1);
    access("R6 supervisor write allowed", 32'h0001_4124, 1, 0, 8'd1);
    access("R5 readonly fill", 32'h0001_1000, 0, 0, 8'd1);
    access("R6 write to readonly", 32'h0001_1000, 1, 0, 8'd1);
    access("R7 global fill", 32'h0001_3300, 0, 1, 8'd1);
    access("R7 global any asid", 32'h0001_3304, 0, 1, 8'd77);

    do_flush();
    access("R8 miss after flush", 32'h0001_0ABC, 0, 1, 8'd1);
    access("R8 refill hit", 32'h0001_0ABC, 0, 1, 8'd1);

    do_flush();
    for (int i = 0; i < 8; i++) access("R9 fill", 32'h0002_0000 + (i << 12), 0, 1, 8'd3);
    access("R9 touch oldest", 32'h0002_0010, 0, 1, 8'd3);
    access("R9 fill when full", 32'h0002_8000, 0, 1, 8'd3);
    access("R9 touched entry kept", 32'h0002_0020, 0, 1, 8'd3);
    access("R9 lru entry evicted", 32'h0002_1000, 0, 1, 8'd3);
    access("R9 next lru evicted", 32'h0002_2000, 0, 1, 8'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule